// File: doc/BRIEF.md
# Boot-Overlay Bus Address Decoder

This block decodes a 24-bit processor bus address into one of three byte-wide memories (boot ROM, main RAM, video RAM) and two write-only control registers. A single bus access moves one, two or four bytes. The byte at the base address is the most significant one. Each following byte has its own address, which is masked inside the region the base address selected, so a multi-byte access that runs off the end of a region wraps back to that region's start.

After reset a boot overlay is active. Every address then has its top bit forced high, so the processor reads its start-up vectors and code from ROM no matter where it points. Software leaves the overlay by writing a control register. A second register drives four active-low indicator LEDs. Reads are combinational. Writes commit on the rising clock edge. An `unmapped` strobe flags any access that finds no target.

Top module: `bdec_top`

## Requirements
- R1: Synchronous reset clears the map-enable flag to 0, so the overlay is active, and sets `led_n` to 4'b1111 (all LEDs dark).
- R2: While `map_enabled` is 0, address bit 23 is ORed to 1 before decoding. A RAM-range or video-range address therefore reaches the ROM window or nothing.
- R3: The ROM window is 0x800000–0xBFFFFF. The byte index is the address masked with ROM_BYTES-1 (16 KiB by default), so the image repeats across the window. The byte at index i is (i*29 + i/256) mod 256.
- R4: Addresses 0 to RAM_WINDOW-1 (512 KiB by default) select RAM when they fall outside the ROM window. A byte index is the address masked with RAM_WINDOW-1, then taken modulo RAM_STORE (1024 bytes of backing storage by default).
- R5: Addresses 0x420000–0x427FFF select video RAM. The byte index is the address masked with 0x7FFF, then taken modulo VRAM_STORE (1024 by default).
- R6: Size code 2'b00 is a byte, 2'b01 a word, and 2'b10 or 2'b11 a longword. Bytes are big-endian, the base address holding the most significant byte. Read data is right-aligned in `bus_rdata`, with the upper bits zero.
- R7: Each byte of a multi-byte access uses base+k masked separately with its region's mask, so the access wraps inside that region.
- R8: A read that finds no target returns 0xFF, 0xFFFF or 0xFFFFFFFF according to its size.
- R9: Writes that decode to the ROM window change nothing.
- R10: A write to 0xE43000 loads the map-enable flag from data bit 7 for a byte write and from data bit 15 for a word or longword write.
- R11: Only a word write to 0x4A0000 loads `led_n` from data bits 11:8. Byte and longword writes there are unmapped and leave `led_n` unchanged.
- R12: Read data is valid in the cycle of the request. Write data, the flag and the LEDs change only at the rising edge that samples `bus_req` and `bus_we` high.
- R13: `bus_unmapped` is high exactly in the cycles of a request that hits no target. Reads of the two register addresses are such requests. With no request, `bus_unmapped` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_req | input | 1 | Access request in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size code |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned |
| bus_unmapped | output | 1 | Request hit no target |
| map_enabled | output | 1 | 1 = overlay off, normal map |
| led_n | output | 4 | Active-low LED drive |

## Verification
A wrong overlay flag shows up in the very next access. RAM and video reads return the ROM pattern or all ones, and RAM writes silently vanish. A byte-lane or wrap error is visible only when the affected bytes are read back. The model therefore reads every written location at more than one width and offset, including accesses that straddle region ends. A stuck LED or flag register is compared against the model after every clock edge, so a wrong value is caught within one cycle of the write that should have changed it, or the write that should not have.

// File: rtl/bdec_pkg.sv
`timescale 1ns/1ps
package bdec_pkg;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;

  // Address map anchors; the decoder's priority order depends on these.
  localparam logic [ADDR_W-1:0] OVERLAY_BIT = 24'h800000;
  localparam logic [ADDR_W-1:0] ROM_LO      = 24'h800000;
  localparam logic [ADDR_W-1:0] ROM_HI      = 24'hBFFFFF;
  localparam logic [ADDR_W-1:0] VID_LO      = 24'h420000;
  localparam logic [ADDR_W-1:0] VID_HI      = 24'h427FFF;
  localparam logic [ADDR_W-1:0] MAPCTL_ADR  = 24'hE43000;
  localparam logic [ADDR_W-1:0] LAMP_ADR    = 24'h4A0000;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_ROM, TGT_RAM, TGT_VID, TGT_MAPCTL, TGT_LAMP
  } target_e;

  typedef logic [3:0][7:0] lanes_t;

  function automatic logic [3:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 4'b0001;
      SZ_WORD: return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] all_ones(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_WORD: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Lane 0 always carries the byte at the base address (most significant).
  function automatic lanes_t split_write(input logic [1:0] sz, input logic [DATA_W-1:0] wd);
    lanes_t l;
    l = '0;
    case (sz)
      SZ_BYTE: l[0] = wd[7:0];
      SZ_WORD: begin
        l[0] = wd[15:8];
        l[1] = wd[7:0];
      end
      default: begin
        l[0] = wd[31:24];
        l[1] = wd[23:16];
        l[2] = wd[15:8];
        l[3] = wd[7:0];
      end
    endcase
    return l;
  endfunction

  function automatic logic [DATA_W-1:0] join_read(input logic [1:0] sz, input lanes_t l);
    case (sz)
      SZ_BYTE: return {24'h0, l[0]};
      SZ_WORD: return {16'h0, l[0], l[1]};
      default: return {l[0], l[1], l[2], l[3]};
    endcase
  endfunction

  // Generated boot image: byte i = i*29 + (i >> 8), modulo 256.
  function automatic logic [7:0] rom_pattern(input logic [ADDR_W-1:0] idx);
    logic [31:0] acc;
    acc = 32'(idx) * 32'd29 + 32'(idx[ADDR_W-1:8]);
    return acc[7:0];
  endfunction

endpackage

// File: rtl/bdec_decode.sv
`timescale 1ns/1ps
module bdec_decode
  import bdec_pkg::*;
#(
  parameter int RAM_WINDOW = 524288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic              map_en,
  output logic [ADDR_W-1:0] eff_addr,
  output target_e           target,
  output logic              unmapped
);

  localparam logic [31:0] RAM_LIMIT = 32'(RAM_WINDOW);

  always_comb begin
    eff_addr = map_en ? addr : (addr | OVERLAY_BIT);
    if (eff_addr >= ROM_LO && eff_addr <= ROM_HI)
      target = TGT_ROM;
    else if (32'(eff_addr) < RAM_LIMIT)
      target = TGT_RAM;
    else if (eff_addr >= VID_LO && eff_addr <= VID_HI)
      target = TGT_VID;
    else if (we && eff_addr == MAPCTL_ADR)
      target = TGT_MAPCTL;
    else if (we && size == SZ_WORD && eff_addr == LAMP_ADR)
      target = TGT_LAMP;
    else
      target = TGT_NONE;
    unmapped = req && (target == TGT_NONE);
  end

  // R2: with the overlay on, nothing below the ROM window can be reached
  p_overlay_rom_r2: assert property (@(posedge clk) disable iff (rst)
    (req && !map_en) |-> (target != TGT_RAM && target != TGT_VID && target != TGT_LAMP));

  // R13: no strobe without a request
  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (rst)
    !req |-> !unmapped);

endmodule

// File: rtl/bdec_byte_store.sv
`timescale 1ns/1ps
module bdec_byte_store
  import bdec_pkg::*;
#(
  parameter int STORE_BYTES = 1024,
  parameter logic [ADDR_W-1:0] WIN_MASK = 24'h07FFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        lane_en,
  input  logic [ADDR_W-1:0] base,
  input  lanes_t            wlanes,
  output lanes_t            rlanes
);

  localparam int IDX_W = $clog2(STORE_BYTES);

  logic [7:0]       mem [STORE_BYTES];
  logic [IDX_W-1:0] idx [4];

  // Every lane wraps inside the region window, then folds onto the storage.
  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign idx[k]    = IDX_W'((base + ADDR_W'(k)) & WIN_MASK);
    assign rlanes[k] = mem[idx[k]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < 4; k++) begin
        if (lane_en[k]) mem[idx[k]] <= wlanes[k];
      end
    end
  end

  // R6: a write drives a contiguous run of lanes starting at the base byte
  p_lane_shape_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (lane_en == 4'b0001 || lane_en == 4'b0011 || lane_en == 4'b1111));

endmodule

// File: rtl/bdec_ctrl_regs.sv
`timescale 1ns/1ps
module bdec_ctrl_regs (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_flag,
  input  logic       flag_bit,
  input  logic       wr_lamp,
  input  logic [3:0] lamp_bits,
  output logic       map_en,
  output logic [3:0] led_n
);

  always_ff @(posedge clk) begin
    if (rst) begin
      map_en <= 1'b0;
      led_n  <= 4'b1111;
    end else begin
      if (wr_flag) map_en <= flag_bit;
      if (wr_lamp) led_n  <= lamp_bits;
    end
  end

  // R10: the flag only moves on a decoded control write
  p_flag_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !wr_flag |=> $stable(map_en));

  // R11: the LEDs only move on a decoded word write
  p_led_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !wr_lamp |=> $stable(led_n));

endmodule

// File: rtl/bdec_top.sv
`timescale 1ns/1ps
module bdec_top
  import bdec_pkg::*;
#(
  parameter int RAM_WINDOW = 524288,
  parameter int RAM_STORE  = 1024,
  parameter int VID_STORE  = 1024,
  parameter int ROM_BYTES  = 16384
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [1:0]  bus_size,
  input  logic [23:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_unmapped,
  output logic        map_enabled
  ,output logic [3:0] led_n
);

  localparam logic [ADDR_W-1:0] ROM_MASK = ADDR_W'(ROM_BYTES - 1);
  localparam logic [ADDR_W-1:0] RAM_MASK = ADDR_W'(RAM_WINDOW - 1);
  localparam logic [ADDR_W-1:0] VID_MASK = VID_HI - VID_LO;

  logic [ADDR_W-1:0] eff_addr;
  target_e           target;
  lanes_t            wlanes, rom_l, ram_l, vid_l;
  logic [3:0]        lane_en;
  logic              do_write, ram_wr, vid_wr, flag_wr, lamp_wr, flag_bit;

  bdec_decode #(.RAM_WINDOW(RAM_WINDOW)) u_decode (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .size(bus_size),
    .addr(bus_addr), .map_en(map_enabled),
    .eff_addr(eff_addr), .target(target), .unmapped(bus_unmapped)
  );

  assign do_write = bus_req && bus_we;
  assign ram_wr   = do_write && (target == TGT_RAM);
  assign vid_wr   = do_write && (target == TGT_VID);
  assign flag_wr  = do_write && (target == TGT_MAPCTL);
  assign lamp_wr  = do_write && (target == TGT_LAMP);
  assign flag_bit = (bus_size == SZ_BYTE) ? bus_wdata[7] : bus_wdata[15];
  assign lane_en  = lane_mask(bus_size);
  assign wlanes   = split_write(bus_size, bus_wdata);

  // ROM lanes come straight from the generated pattern.
  for (genvar k = 0; k < 4; k++) begin : g_rom
    assign rom_l[k] = rom_pattern((eff_addr + ADDR_W'(k)) & ROM_MASK);
  end

  bdec_byte_store #(.STORE_BYTES(RAM_STORE), .WIN_MASK(RAM_MASK)) u_ram (
    .clk(clk), .rst(rst), .wr_en(ram_wr), .lane_en(lane_en),
    .base(eff_addr), .wlanes(wlanes), .rlanes(ram_l)
  );

  bdec_byte_store #(.STORE_BYTES(VID_STORE), .WIN_MASK(VID_MASK)) u_vid (
    .clk(clk), .rst(rst), .wr_en(vid_wr), .lane_en(lane_en),
    .base(eff_addr), .wlanes(wlanes), .rlanes(vid_l)
  );

  bdec_ctrl_regs u_ctrl (
    .clk(clk), .rst(rst),
    .wr_flag(flag_wr), .flag_bit(flag_bit),
    .wr_lamp(lamp_wr), .lamp_bits(bus_wdata[11:8]),
    .map_en(map_enabled), .led_n(led_n)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_req && !bus_we) begin
      case (target)
        TGT_ROM: bus_rdata = join_read(bus_size, rom_l);
        TGT_RAM: bus_rdata = join_read(bus_size, ram_l);
        TGT_VID: bus_rdata = join_read(bus_size, vid_l);
        default: bus_rdata = all_ones(bus_size);
      endcase
    end
  end

  // R8: an unmapped read floats high at its own width
  p_unmapped_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && bus_unmapped) |-> (bus_rdata == all_ones(bus_size)));

  // R13: an idle bus returns zero data
  p_idle_data_r13: assert property (@(posedge clk) disable iff (rst)
    !bus_req |-> (bus_rdata == 32'h0));

  // R9: nothing below the ROM is written while the overlay is on
  p_overlay_nowrite_r9: assert property (@(posedge clk) disable iff (rst)
    !map_enabled |-> (!ram_wr && !vid_wr && !lamp_wr));

endmodule

// File: tb/bdec_top_test.sv
`timescale 1ns/1ps
module bdec_top_test;

  localparam int RAM_WINDOW = 524288;
  localparam int RAM_STORE  = 1024;
  localparam int VID_STORE  = 1024;
  localparam int ROM_BYTES  = 16384;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_size = 2'b00;
  logic [23:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_unmapped;
  logic        map_enabled;
  logic [3:0]  led_n;

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [7:0] m_ram [RAM_STORE];
  logic [7:0] m_vid [VID_STORE];
  bit         m_map;
  logic [3:0] m_led;

  always #4 clk = ~clk;

  bdec_top uut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_unmapped(bus_unmapped),
    .map_enabled(map_enabled), .led_n(led_n)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input int sz);
    if (sz == 0) return 1;
    if (sz == 1) return 2;
    return 4;
  endfunction

  // 1 rom, 2 ram, 3 video, 4 flag reg, 5 led reg, 0 nothing
  function automatic int classify(input int a, input bit we, input int sz);
    if (a >= 'h800000 && a < 'hC00000) return 1;
    if (a < RAM_WINDOW) return 2;
    if (a >= 'h420000 && a < 'h428000) return 3;
    if (we && a == 'hE43000) return 4;
    if (we && sz == 1 && a == 'h4A0000) return 5;
    return 0;
  endfunction

  function automatic int pick_byte(input int where, input int a);
    int i;
    if (where == 1) begin
      i = a % ROM_BYTES;
      return ((i * 29) + (i / 256)) % 256;
    end
    if (where == 2) return int'(m_ram[(a % RAM_WINDOW) % RAM_STORE]);
    return int'(m_vid[(a % 32768) % VID_STORE]);
  endfunction

  task automatic access(input string tag, input bit we, input int sz, input int a, input logic [31:0] wd);
    int eff, where, n;
    longint expv;
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_size = sz[1:0]; bus_addr = a[23:0]; bus_wdata = wd;
    #2;
    eff   = m_map ? a : (a | 'h800000);
    where = classify(eff, we, sz);
    n     = width_of(sz);
    expv  = 0;
    if (!we) begin
      if (where == 0) expv = (64'd1 << (8 * n)) - 1;
      else for (int k = 0; k < n; k++) expv = (expv << 8) | longint'(pick_byte(where, eff + k));
    end
    chk({tag, " data"}, longint'(bus_rdata), expv);
    chk({tag, " unmapped R13"}, longint'(bus_unmapped), longint'(where == 0));
    @(posedge clk);
    if (we) begin
      for (int k = 0; k < n; k++) begin
        int b;
        b = int'((wd >> (8 * (n - 1 - k))) & 32'hFF);
        if (where == 2) m_ram[((eff + k) % RAM_WINDOW) % RAM_STORE] = 8'(b);
        if (where == 3) m_vid[((eff + k) % 32768) % VID_STORE] = 8'(b);
      end
      if (where == 4) m_map = (sz == 0) ? wd[7] : wd[15];
      if (where == 5) m_led = wd[11:8];
    end
    #1;
    chk({tag, " flag R10"}, longint'(map_enabled), longint'(m_map));
    chk({tag, " leds R11"}, longint'(led_n), longint'(m_led));
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1; bus_req = 1'b0;
    @(posedge clk); #1;
    m_map = 1'b0; m_led = 4'hF;
    chk({tag, " flag after reset"}, longint'(map_enabled), 0);
    chk({tag, " leds after reset"}, longint'(led_n), 'hF);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < RAM_STORE; i++) m_ram[i] = 8'h00;
    for (int i = 0; i < VID_STORE; i++) m_vid[i] = 8'h00;
    repeat (2) @(posedge clk);
    do_reset("R1");

    // R2: overlay steers low addresses into ROM
    access("R2 long", 0, 2, 'h000010, 0);
    access("R2 byte", 0, 0, 'h003FFF, 0);
    access("R2 word", 0, 1, 'h000101, 0);
    // R9: write aimed at RAM lands in ROM window and vanishes
    access("R9 overlay wr", 1, 1, 'h000100, 32'hBEEF);
    access("R9 overlay rd", 0, 1, 'h000100, 0);
    // R11: LED address unreachable under overlay
    access("R11 overlay led", 1, 1, 'h4A0000, 32'h0500);
    // R10: byte write bit7=0 keeps overlay; word write bit15 leaves it
    access("R10 byte clear", 1, 0, 'hE43000, 32'h0000_8000);
    access("R10 word set", 1, 1, 'hE43000, 32'h0000_8000);

    // R4, R6: RAM big-endian at each width
    access("R4 wr long", 1, 2, 'h000200, 32'h11223344);
    access("R4 rd long", 0, 2, 'h000200, 0);
    access("R6 rd word", 0, 1, 'h000202, 0);
    access("R6 rd byte", 0, 0, 'h000201, 0);
    access("R6 size3", 0, 3, 'h000200, 0);
    access("R6 wr word", 1, 1, 'h000210, 32'hFFFF_CAFE);
    access("R6 rd long mix", 0, 2, 'h00020E, 0);
    // R7: wrap at the top of the RAM window
    access("R7 ram wr wrap", 1, 2, 'h07FFFE, 32'hA1B2C3D4);
    access("R7 ram rd wrap", 0, 2, 'h07FFFE, 0);
    access("R7 ram rd low", 0, 1, 'h000000, 0);

    // R3: ROM contents, mirroring, wrap at window top
    access("R3 rom base", 0, 2, 'h800000, 0);
    access("R3 rom mirror", 0, 2, 'h804000, 0);
    access("R3 rom top", 0, 2, 'hBFFFFE, 0);
    access("R9 rom wr", 1, 2, 'h800000, 32'h0);
    access("R9 rom rd", 0, 2, 'h800000, 0);

    // R5, R7: video RAM
    access("R5 vid wr", 1, 2, 'h427FFE, 32'h55667788);
    access("R5 vid rd", 0, 2, 'h427FFE, 0);
    access("R7 vid low", 0, 1, 'h420000, 0);
    access("R5 vid wr byte", 1, 0, 'h420010, 32'h9A);
    access("R5 vid rd byte", 0, 0, 'h420010, 0);

    // R8, R13: unmapped space
    access("R8 byte", 0, 0, 'h500000, 0);
    access("R8 word", 0, 1, 'h500000, 0);
    access("R8 long", 0, 2, 'h500000, 0);
    access("R13 wr none", 1, 2, 'h600000, 32'h12345678);
    access("R13 rd flagreg", 0, 1, 'hE43000, 0);
    access("R13 rd ledreg", 0, 1, 'h4A0000, 0);

    // R11: LED register
    access("R11 word", 1, 1, 'h4A0000, 32'h0A00);
    access("R11 byte", 1, 0, 'h4A0000, 32'h00FF);
    access("R11 long", 1, 2, 'h4A0000, 32'h0000_0000);

    // R10: longword clears flag from bit 15, overlay returns
    access("R10 long clear", 1, 2, 'hE43000, 32'hFFFF_7FFF);
    access("R2 back in rom", 0, 2, 'h000200, 0);
    access("R10 byte set", 1, 0, 'hE43000, 32'h80);
    access("R4 ram kept", 0, 2, 'h000200, 0);

    // R13: idle bus
    @(negedge clk); #2;
    chk("R13 idle unmapped", longint'(bus_unmapped), 0);
    chk("R13 idle data", longint'(bus_rdata), 0);

    // R12: synchronous reset mid-run
    do_reset("R12");
    access("R12 after reset", 0, 2, 'h000200, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule